// File: doc/BRIEF.md
# DMA Transfer Address and Count Engine

This block holds the memory address and the transfer count of every DMA channel and steps them as transfers complete. A host-side loader writes each channel's 16-bit address and 16-bit count word. The count word has a 14-bit remaining-cycle field in bits 13:0, which holds n-1 for a block of n cycles, and a 2-bit transfer-type tag in bits 15:14 that the block carries along unchanged. Each time the bus sequencer finishes a transfer cycle it pulses `cyc_done` together with the channel index `cyc_ch`. On that clock the channel's address rises by one and its remaining-cycle field falls by one.

While a cycle is in progress, the block reports three things about the channel on `cyc_ch`. It shows the current address and count word. It raises a last-cycle flag when the remaining field is zero. It raises a mark flag when the low seven bits of that field are zero. The mark flag therefore lands on every 128th cycle from the block start when the block length is a multiple of 128. When a cycle completes on a zero count, the block pulses a terminal-count event for that channel. If stop-at-count mode is on, it also pulses a disable request for that channel. With chaining enabled, channel 2 reaching terminal count copies channel 3's address and count into channel 2 and sets an update flag. The update flag clears when the first cycle of the reloaded block completes.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset every channel's address and count word are zero and `upd_flag` is low.
- R2: A load with `ld_en` high writes `ld_data` into the address (`ld_cnt`=0) or the count word (`ld_cnt`=1) of channel `ld_ch` at the next clock edge.
- R3: A `cyc_done` pulse on an enabled channel increments its address by one and decrements bits 13:0 of its count by one at that edge. Bits 15:14 are kept.
- R4: `last_cyc` is high while bits 13:0 of the count of channel `cyc_ch` are zero.
- R5: `mark` is high while bits 6:0 of the count of channel `cyc_ch` are zero. For a block of 256 cycles it is high on cycles 128 and 256 only.
- R6: A cycle completing with a zero count raises `tc_evt[ch]` in the same clock. If no reload applies, the count field wraps to 3FFF (hex) and the address still increments.
- R7: `dis_req[ch]` pulses together with `tc_evt[ch]` when `stop_on_tc` is high. It stays low when `stop_on_tc` is low.
- R8: A `cyc_done` on a channel whose `chan_en` bit is low changes no state and raises no event.
- R9: With `autoload` high, terminal count on channel 2 loads channel 2's address and count from channel 3 and sets `upd_flag`. Channel 3 is left unchanged.
- R10: With `upd_flag` set, the next completed cycle on channel 2 clears the flag and steps channel 2 normally.
- R11: `upd_flag` is cleared at the clock edge after `autoload` is low.
- R12: A load and a `cyc_done` to the same channel in one clock apply the load only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | NCH | Per-channel enable bits |
| stop_on_tc | input | 1 | Request disable of a channel at its terminal count |
| autoload | input | 1 | Enable chaining of channel 2 from channel 3 |
| cyc_done | input | 1 | One-clock pulse: a transfer cycle has completed |
| cyc_ch | input | CHW | Channel of the active cycle; also selects the status outputs |
| ld_en | input | 1 | Load strobe |
| ld_ch | input | CHW | Channel to load |
| ld_cnt | input | 1 | 0 selects the address, 1 selects the count word |
| ld_data | input | AW | Load value; the count word takes bits CW+1:0 |
| cur_addr | output | AW | Address of channel `cyc_ch` |
| cur_cnt | output | CW+2 | Count word of channel `cyc_ch` |
| last_cyc | output | 1 | Active channel is on its final cycle |
| mark | output | 1 | Active channel is on a modulo-128 cycle |
| tc_evt | output | NCH | Per-channel terminal-count pulse |
| dis_req | output | NCH | Per-channel disable request pulse |
| upd_flag | output | 1 | Channel 2 is running a reloaded block whose first cycle is pending |

## Verification
The stepping logic is driven with three kinds of count. A short block with a non-zero type tag shows whether decrement and wrap preserve the tag. A block starting at 80 (hex) with the address at FFFF shows address rollover, and shows a mark on a count that is not a multiple of 128. A 256-cycle block tells a true modulo-128 mark apart from the last-cycle flag. The chaining path is exercised with back-to-back terminal counts on channel 2, with chaining on and then off. This shows that reload, flag set, flag clear and plain wrap are each chosen in the right case.

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
  parameter int NCH     = 4,
  parameter int AW      = 16,
  parameter int CW      = 14,
  parameter int MARK_W  = 7,
  parameter int RLD_DST = 2,
  parameter int RLD_SRC = 3,
  localparam int CHW    = $clog2(NCH),
  localparam int RW     = CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic           stop_on_tc,
  input  logic           autoload,
  input  logic           cyc_done,
  input  logic [CHW-1:0] cyc_ch,
  input  logic           ld_en,
  input  logic [CHW-1:0] ld_ch,
  input  logic           ld_cnt,
  input  logic [AW-1:0]  ld_data,
  output logic [AW-1:0]  cur_addr,
  output logic [RW-1:0]  cur_cnt,
  output logic           last_cyc,
  output logic           mark,
  output logic [NCH-1:0] tc_evt,
  output logic [NCH-1:0] dis_req,
  output logic           upd_flag
);

  logic [NCH-1:0][AW-1:0] addr_q;
  logic [NCH-1:0][RW-1:0] cnt_q;
  logic [NCH-1:0]         adv;
  logic [NCH-1:0]         zero;
  logic [NCH-1:0]         hit_ld;
  logic                   rld_now;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign hit_ld[c]  = ld_en && (ld_ch == CHW'(c));
    assign adv[c]     = cyc_done && (cyc_ch == CHW'(c)) && chan_en[c] && !hit_ld[c];
    assign zero[c]    = (cnt_q[c][CW-1:0] == '0);
    assign tc_evt[c]  = adv[c] && zero[c];
    assign dis_req[c] = tc_evt[c] && stop_on_tc;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv[c] && !(c == RLD_DST && rld_now)) |=> addr_q[c] == $past(addr_q[c]) + AW'(1)); // R3
    AST_TYPE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv[c] && !(c == RLD_DST && rld_now)) |=> cnt_q[c][RW-1:CW] == $past(cnt_q[c][RW-1:CW])); // R3
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_done && cyc_ch == CHW'(c) && !chan_en[c] && !hit_ld[c]) |=> $stable(addr_q[c]) && $stable(cnt_q[c])); // R8
  end

  assign rld_now = autoload && adv[RLD_DST] && zero[RLD_DST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (hit_ld[c]) begin
          if (ld_cnt) cnt_q[c] <= ld_data[RW-1:0];
          else        addr_q[c] <= ld_data;
        end else if (c == RLD_DST && rld_now) begin
          addr_q[c] <= addr_q[RLD_SRC];
          cnt_q[c]  <= cnt_q[RLD_SRC];
        end else if (adv[c]) begin
          addr_q[c] <= addr_q[c] + AW'(1);
          cnt_q[c]  <= {cnt_q[c][RW-1:CW], cnt_q[c][CW-1:0] - CW'(1)};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             upd_flag <= 1'b0;
    else if (!autoload)     upd_flag <= 1'b0;
    else if (rld_now)       upd_flag <= 1'b1;
    else if (adv[RLD_DST])  upd_flag <= 1'b0;
  end

  assign cur_addr = addr_q[cyc_ch];
  assign cur_cnt  = cnt_q[cyc_ch];
  assign last_cyc = (cnt_q[cyc_ch][CW-1:0] == '0);
  assign mark     = (cnt_q[cyc_ch][MARK_W-1:0] == '0);

  AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rld_now |=> upd_flag); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !autoload |=> !upd_flag); // R11
  AST_TC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_evt)); // R6
  AST_DIS_WITH_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_req & ~tc_evt) == '0); // R7

endmodule

// File: tb/dma_xfer_counter_tb.sv
`timescale 1ns/1ps
module dma_xfer_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  chan_en = 4'hF;
  logic        stop_on_tc = 1'b0, autoload = 1'b0;
  logic        cyc_done = 1'b0, ld_en = 1'b0, ld_cnt = 1'b0;
  logic [1:0]  cyc_ch = '0, ld_ch = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] cur_addr, cur_cnt;
  logic        last_cyc, mark, upd_flag;
  logic [3:0]  tc_evt, dis_req;

  logic        s_last, s_mark;
  logic [3:0]  s_tc, s_dis;
  int          checks = 0, fails = 0;

  always #10 clk = ~clk;

  dma_xfer_counter dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .stop_on_tc(stop_on_tc),
    .autoload(autoload), .cyc_done(cyc_done), .cyc_ch(cyc_ch), .ld_en(ld_en),
    .ld_ch(ld_ch), .ld_cnt(ld_cnt), .ld_data(ld_data), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .last_cyc(last_cyc), .mark(mark), .tc_evt(tc_evt),
    .dis_req(dis_req), .upd_flag(upd_flag));

  // op: 0 load address, 1 load count, 2 cycle done
  // fields: op(2) ch(2) data(16) exp_addr(16) exp_cnt(16) exp_last exp_mark exp_tc
  localparam logic [54:0] VEC [9] = '{
    {2'd0, 2'd0, 16'h1000, 16'h1000, 16'h0000, 3'b000},
    {2'd1, 2'd0, 16'h4002, 16'h1000, 16'h4002, 3'b000},
    {2'd2, 2'd0, 16'h0000, 16'h1001, 16'h4001, 3'b000},
    {2'd2, 2'd0, 16'h0000, 16'h1002, 16'h4000, 3'b000},
    {2'd2, 2'd0, 16'h0000, 16'h1003, 16'h7FFF, 3'b111},
    {2'd0, 2'd1, 16'hFFFF, 16'hFFFF, 16'h0000, 3'b000},
    {2'd1, 2'd1, 16'h8080, 16'hFFFF, 16'h8080, 3'b000},
    {2'd2, 2'd1, 16'h0000, 16'h0000, 16'h807F, 3'b010},
    {2'd2, 2'd1, 16'h0000, 16'h0001, 16'h807E, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic dn, input logic ld, input logic sel,
                       input logic [1:0] ch, input logic [15:0] d);
    @(negedge clk);
    cyc_done = dn; cyc_ch = ch; ld_en = ld; ld_ch = ch; ld_cnt = sel; ld_data = d;
    #2;
    s_last = last_cyc; s_mark = mark; s_tc = tc_evt; s_dis = dis_req;
    @(posedge clk);
    #1;
    cyc_done = 1'b0; ld_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] ch);
    cyc_ch = ch;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int nmark;
    logic pos_ok;
    #35 rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      peek(2'(c));
      chk("R1 addr", cur_addr, 16'h0);
      chk("R1 cnt", cur_cnt, 16'h0);
    end
    chk("R1 upd_flag", upd_flag, 0);

    for (int i = 0; i < 9; i++) begin
      logic [54:0] v;
      v = VEC[i];
      drive(v[54:53] == 2'd2, v[54:53] != 2'd2, v[53], v[52:51], v[50:35]);
      peek(v[52:51]);
      chk(v[54:53] == 2'd2 ? "R3 step" : "R2 load", {cur_addr, cur_cnt}, {v[34:19], v[18:3]});
      if (v[54:53] == 2'd2)
        chk("R4 R5 R6 flags", {s_last, s_mark, s_tc[v[52:51]]}, v[2:0]);
    end

    // R8: disabled channel ignores cycle done
    chan_en = 4'b1101;
    drive(1'b1, 1'b0, 1'b0, 2'd1, 16'h0);
    peek(2'd1);
    chk("R8 state", {cur_addr, cur_cnt}, {16'h0001, 16'h807E});
    chk("R8 event", s_tc, 4'h0);
    chan_en = 4'hF;

    // R12: load wins over a same-cycle step
    drive(1'b1, 1'b1, 1'b0, 2'd1, 16'h0ABC);
    peek(2'd1);
    chk("R12 load wins", {cur_addr, cur_cnt}, {16'h0ABC, 16'h807E});

    // R7: disable request only with stop_on_tc
    drive(1'b0, 1'b1, 1'b1, 2'd0, 16'h0000);
    stop_on_tc = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
    chk("R7 dis with stop", {s_dis, s_tc}, {4'b0001, 4'b0001});
    peek(2'd0);
    chk("R6 wrap", {cur_addr, cur_cnt}, {16'h1004, 16'h3FFF});
    drive(1'b0, 1'b1, 1'b1, 2'd0, 16'h0000);
    stop_on_tc = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
    chk("R7 no dis without stop", {s_dis, s_tc}, {4'b0000, 4'b0001});

    // R5: 256-cycle block, mark on 128 and 256, last on 256 only
    drive(1'b0, 1'b1, 1'b1, 2'd1, 16'h00FF);
    nmark = 0; pos_ok = 1'b1;
    for (int k = 1; k <= 256; k++) begin
      drive(1'b1, 1'b0, 1'b0, 2'd1, 16'h0);
      if (s_mark) begin
        nmark++;
        if (k != 128 && k != 256) pos_ok = 1'b0;
      end
      if (s_last != (k == 256)) pos_ok = 1'b0;
    end
    chk("R5 mark count", nmark, 2);
    chk("R5 R4 positions", pos_ok, 1'b1);

    // R9 R10 R11 R6: chaining of channel 2 from channel 3
    drive(1'b0, 1'b1, 1'b0, 2'd3, 16'h2000);
    drive(1'b0, 1'b1, 1'b1, 2'd3, 16'h8001);
    drive(1'b0, 1'b1, 1'b0, 2'd2, 16'h0500);
    drive(1'b0, 1'b1, 1'b1, 2'd2, 16'h8000);
    autoload = 1'b1;
    chk("R9 flag before", upd_flag, 0);
    drive(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
    chk("R9 tc event", s_tc, 4'b0100);
    peek(2'd2);
    chk("R9 reload", {cur_addr, cur_cnt}, {16'h2000, 16'h8001});
    chk("R9 flag set", upd_flag, 1);
    peek(2'd3);
    chk("R9 source kept", {cur_addr, cur_cnt}, {16'h2000, 16'h8001});
    drive(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
    peek(2'd2);
    chk("R10 step", {cur_addr, cur_cnt}, {16'h2001, 16'h8000});
    chk("R10 flag clear", upd_flag, 0);
    drive(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
    peek(2'd2);
    chk("R9 second reload", {cur_addr, cur_cnt, 15'h0, upd_flag}, {16'h2000, 16'h8001, 16'h0001});
    @(negedge clk); autoload = 1'b0;
    @(posedge clk); #1;
    chk("R11 flag drop", upd_flag, 0);
    drive(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
    drive(1'b1, 1'b0, 1'b0, 2'd2, 16'h0);
    chk("R6 tc no chain", s_tc, 4'b0100);
    peek(2'd2);
    chk("R6 wrap no reload", {cur_addr, cur_cnt}, {16'h2002, 16'hBFFF});

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule